// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block gives host software a two-address configuration window: a register number is written to the lower address, then the register is read or written through the upper address. The window stays shut until a two-byte key has been written to the lower address. A separate closing byte shuts it again. While the window is shut, ordinary I/O traffic to the two addresses cannot change any configuration state by accident.

Behind the window sit three groups of registers. The first is a set of read-only identity bytes. The second is a small bank of writable registers shared by the whole chip, plus a device-number selector. The third is the per-device area at 0x30 and above. The block keeps the enable bit of each logical device at 0x30 itself. Every other per-device register is handed to downstream logic through decoded read and write strobes, which carry the register number and the selected device. The pair of I/O addresses comes from a strap input.

Top module: `cfgp_top`

## Requirements
- R1: The port answers only at its two addresses: base and base+1, where base is 0x2E when `base_sel`=0 and 0x4E when `base_sel`=1. Accesses at any other address change no state, and reads there return 0xFF.
- R2: Writing 0x87 to the index address twice in a row opens the window. Opening leaves the index register unchanged, and the index is 0x00 after reset.
- R3: While one 0x87 has been seen, a write of any other byte to the index address, or any write to the data address, cancels the sequence. A fresh pair of 0x87 writes is then needed to open the window.
- R4: While the window is shut, reads of the data address return 0xFF, and writes to either address change no register (the index register included). No downstream strobe is raised.
- R5: Writing 0xAA to the index address while the window is open shuts it. The index register keeps its value.
- R6: Registers 0x20, 0x21 and 0x22 read as device ID high byte, device ID low byte and revision. Registers 0x23 and 0x24 read as 0x19 and 0x34, the maker ID high byte first. Writes to these five registers are ignored.
- R7: Register 0x07 is an 8-bit read/write logical-device select. Its value appears on `ld_sel`, and it resets to 0.
- R8: Register 0x30 bit 0 is the enable of the selected logical device. It drives bit n of `ld_en` for device n, and the other bits of 0x30 read as 0. A select value of NUM_LD or more reads 0x00 and ignores writes. All enables reset to 0.
- R9: An open data-port write or read to an index above 0x30 raises `ld_wr` or `ld_rd` in the same cycle, with `ld_idx` set to the index and `ld_wdata` set to the written byte. A read returns `ld_rdata`. Accesses at index 0x30 or below raise no strobe.
- R10: Registers 0x25 to 0x2F are read/write global storage that is shared whatever the select value. Other unlisted indices below 0x30 read 0x00 and ignore writes.
- R11: `io_rdata` is registered. It takes its new value on the clock edge that samples `io_rd` and holds it until the next read. An index-address read returns the index while the window is open and 0xFF while it is shut. After reset `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Address strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| ld_sel | output | 8 | Current logical-device select |
| ld_en | output | NUM_LD | Per-device enable bits |
| ld_wr | output | 1 | Downstream register write strobe |
| ld_rd | output | 1 | Downstream register read strobe |
| ld_idx | output | 8 | Downstream register number |
| ld_wdata | output | 8 | Downstream write byte |
| ld_rdata | input | 8 | Downstream read byte, valid in the cycle of `ld_rd` |

## Verification
A key state machine stuck open or stuck halfway through the key would show at the ports on the very next data read. That read returns register contents where 0xFF is expected, or 0xFF where contents are expected. A missed ignore would surface later: an index or global byte that changed while the window was shut reads back wrong after the next unlock. The downstream strobe fields are sampled inside the access cycle, so a wrong index or a misdirected write to 0x30 shows within that same cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam logic [7:0] KEY_OPEN_B  = 8'h87;
    localparam logic [7:0] KEY_SHUT_B  = 8'hAA;

    localparam logic [7:0] R_LDSEL     = 8'h07;
    localparam logic [7:0] R_DEV_HI    = 8'h20;
    localparam logic [7:0] R_DEV_LO    = 8'h21;
    localparam logic [7:0] R_REV       = 8'h22;
    localparam logic [7:0] R_MFG_HI    = 8'h23;
    localparam logic [7:0] R_MFG_LO    = 8'h24;
    localparam logic [7:0] R_GLB_LO    = 8'h25;
    localparam logic [7:0] R_GLB_HI    = 8'h2F;
    localparam logic [7:0] R_LD_EN     = 8'h30;

    localparam logic [15:0] MFG_ID     = 16'h1934;
    localparam int          GLB_N      = int'(R_GLB_HI) - int'(R_GLB_LO) + 1;
    localparam int          GLB_AW     = $clog2(GLB_N);

    typedef enum logic [1:0] {
        KS_SHUT = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_e;

    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
        logic miss_rd;
    } port_req_t;

    function automatic logic [15:0] base_of(input logic sel);
        return sel ? 16'h004E : 16'h002E;
    endfunction

endpackage

// File: rtl/cfgp_port_dec.sv
module cfgp_port_dec
    import cfgp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output port_req_t         req
);
    logic [ADDR_W-1:0] base_a;
    logic              hit_idx;
    logic              hit_dat;

    always_comb begin
        base_a  = ADDR_W'(base_of(base_sel));
        hit_idx = (io_addr == base_a);
        hit_dat = (io_addr == base_a + ADDR_W'(1));
        req.idx_wr  = io_wr & hit_idx;
        req.idx_rd  = io_rd & hit_idx;
        req.dat_wr  = io_wr & hit_dat;
        req.dat_rd  = io_rd & hit_dat;
        req.miss_rd = io_rd & ~hit_idx & ~hit_dat;
    end
endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req,
    input  logic [7:0] wdata,
    output logic      cfg_open,
    output logic      idx_load
);
    key_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KS_SHUT: begin
                if (req.idx_wr && wdata == KEY_OPEN_B) st_d = KS_HALF;
            end
            KS_HALF: begin
                if (req.idx_wr) st_d = (wdata == KEY_OPEN_B) ? KS_OPEN : KS_SHUT;
                else if (req.dat_wr) st_d = KS_SHUT;
            end
            KS_OPEN: begin
                if (req.idx_wr && wdata == KEY_SHUT_B) st_d = KS_SHUT;
            end
            default: st_d = KS_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KS_SHUT;
        else     st_q <= st_d;
    end

    assign cfg_open = (st_q == KS_OPEN);
    assign idx_load = cfg_open && req.idx_wr && (wdata != KEY_SHUT_B);
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
    import cfgp_pkg::*;
#(
    parameter int          NUM_LD  = 4,
    parameter logic [15:0] DEV_ID  = 16'h0A51,
    parameter logic [7:0]  DEV_REV = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req,
    input  logic [7:0]        wdata,
    input  logic              cfg_open,
    input  logic              idx_load,
    input  logic [7:0]        ld_rdata,
    output logic [7:0]        index,
    output logic [7:0]        ld_sel,
    output logic [NUM_LD-1:0] ld_en,
    output logic              ld_wr,
    output logic              ld_rd,
    output logic [7:0]        io_rdata
);
    logic [7:0]        glb_q [GLB_N];
    logic [NUM_LD-1:0] sel_hot;
    logic              reg_wr, reg_rd;
    logic              in_glb, in_ld;
    logic [7:0]        glb_off;
    logic              en_cur;
    logic [7:0]        rd_val;
    logic [7:0]        rdata_d;

    assign reg_wr  = req.dat_wr & cfg_open;
    assign reg_rd  = req.dat_rd & cfg_open;
    assign in_glb  = (index >= R_GLB_LO) && (index <= R_GLB_HI);
    assign in_ld   = (index > R_LD_EN);
    assign glb_off = index - R_GLB_LO;
    assign ld_wr   = reg_wr & in_ld;
    assign ld_rd   = reg_rd & in_ld;

    // index register
    always_ff @(posedge clk) begin
        if (rst)           index <= 8'h00;
        else if (idx_load) index <= wdata;
    end

    // device select
    always_ff @(posedge clk) begin
        if (rst)                               ld_sel <= 8'h00;
        else if (reg_wr && index == R_LDSEL)   ld_sel <= wdata;
    end

    // per-device enable flops
    for (genvar g = 0; g < NUM_LD; g++) begin : g_en
        assign sel_hot[g] = (ld_sel == 8'(g));
        always_ff @(posedge clk) begin
            if (rst) ld_en[g] <= 1'b0;
            else if (reg_wr && index == R_LD_EN && sel_hot[g]) ld_en[g] <= wdata[0];
        end
    end
    assign en_cur = |(ld_en & sel_hot);

    // shared global bank
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLB_N; i++) glb_q[i] <= 8'h00;
        end else if (reg_wr && in_glb) begin
            glb_q[glb_off[GLB_AW-1:0]] <= wdata;
        end
    end

    always_comb begin
        unique case (index)
            R_LDSEL:  rd_val = ld_sel;
            R_DEV_HI: rd_val = DEV_ID[15:8];
            R_DEV_LO: rd_val = DEV_ID[7:0];
            R_REV:    rd_val = DEV_REV;
            R_MFG_HI: rd_val = MFG_ID[15:8];
            R_MFG_LO: rd_val = MFG_ID[7:0];
            R_LD_EN:  rd_val = {7'b0, en_cur};
            default: begin
                if (in_ld)       rd_val = ld_rdata;
                else if (in_glb) rd_val = glb_q[glb_off[GLB_AW-1:0]];
                else             rd_val = 8'h00;
            end
        endcase
    end

    always_comb begin
        if (req.dat_rd)      rdata_d = cfg_open ? rd_val : 8'hFF;
        else if (req.idx_rd) rdata_d = cfg_open ? index  : 8'hFF;
        else                 rdata_d = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) io_rdata <= 8'hFF;
        else if (req.dat_rd || req.idx_rd || req.miss_rd) io_rdata <= rdata_d;
    end
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          NUM_LD  = 4,
    parameter logic [15:0] DEV_ID  = 16'h0A51,
    parameter logic [7:0]  DEV_REV = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [7:0]        ld_sel,
    output logic [NUM_LD-1:0] ld_en,
    output logic              ld_wr,
    output logic              ld_rd,
    output logic [7:0]        ld_idx,
    output logic [7:0]        ld_wdata,
    input  logic [7:0]        ld_rdata
);
    port_req_t  req;
    logic       cfg_open;
    logic       idx_load;
    logic [7:0] index;

    cfgp_port_dec #(.ADDR_W(ADDR_W)) u_dec (
        .base_sel (base_sel),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .req      (req)
    );

    cfgp_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    cfgp_regbank #(.NUM_LD(NUM_LD), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load),
        .ld_rdata (ld_rdata),
        .index    (index),
        .ld_sel   (ld_sel),
        .ld_en    (ld_en),
        .ld_wr    (ld_wr),
        .ld_rd    (ld_rd),
        .io_rdata (io_rdata)
    );

    assign ld_idx   = index;
    assign ld_wdata = io_wdata;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int NUM_LD = 4
) (
    input logic              clk,
    input logic              rst,
    input port_req_t         req,
    input logic              cfg_open,
    input logic [7:0]        index,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              ld_wr,
    input logic              ld_rd,
    input logic [7:0]        ld_idx,
    input logic [NUM_LD-1:0] ld_en
);
    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(req.idx_wr && io_wdata == KEY_OPEN_B));

    p_shut_read_ff_r4: assert property (@(posedge clk) disable iff (rst)
        (req.dat_rd && !cfg_open) |=> (io_rdata == 8'hFF));

    p_no_strobe_shut_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_wr || ld_rd) |-> cfg_open);

    p_close_key_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && req.idx_wr && io_wdata == KEY_SHUT_B) |=> !cfg_open);

    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst || !started)
        !(req.dat_wr && cfg_open && index == R_LD_EN) |=> $stable(ld_en));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_wr, ld_rd}));

    p_strobe_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (ld_wr || ld_rd) |-> (ld_idx > R_LD_EN));
endmodule

bind cfgp_top cfgp_checker #(.NUM_LD(NUM_LD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .cfg_open (cfg_open),
    .index    (index),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .ld_wr    (ld_wr),
    .ld_rd    (ld_rd),
    .ld_idx   (ld_idx),
    .ld_en    (ld_en)
);

// File: tb/tb_cfgp_top.sv
`timescale 1ns/1ps
module tb_cfgp_top;
    localparam int NUM_LD = 4;

    logic clk = 0;
    logic rst = 1;
    logic base_sel = 0;
    logic [15:0] io_addr = 0;
    logic io_wr = 0, io_rd = 0;
    logic [7:0] io_wdata = 0;
    logic [7:0] io_rdata;
    logic [7:0] ld_sel;
    logic [NUM_LD-1:0] ld_en;
    logic ld_wr, ld_rd;
    logic [7:0] ld_idx, ld_wdata, ld_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb[$];

    logic cap_wr, cap_rd;
    logic [7:0] cap_idx, cap_wdata;
    logic rd_d = 0;

    always #10 clk = ~clk;

    assign ld_rdata = ld_idx ^ 8'hA5;

    cfgp_top #(.NUM_LD(NUM_LD)) dut (
        .clk(clk), .rst(rst), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ld_sel(ld_sel), .ld_en(ld_en), .ld_wr(ld_wr), .ld_rd(ld_rd),
        .ld_idx(ld_idx), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: read data appears the cycle after the strobe
    always @(posedge clk) rd_d <= io_rd & ~rst;
    always @(negedge clk) begin
        if (rd_d) begin
            if (sb.size() == 0) check(1'b0, "SB_EMPTY", io_rdata, 8'h00);
            else begin
                exp_t e;
                e = sb.pop_front();
                check(io_rdata == e.exp, e.tag, io_rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        #1;
        cap_wr = ld_wr; cap_idx = ld_idx; cap_wdata = ld_wdata;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        io_addr = a; io_rd = 1;
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
        #1;
        cap_rd = ld_rd;
        @(negedge clk);
        io_rd = 0;
    endtask

    localparam logic [15:0] IX = 16'h002E, DT = 16'h002F;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(io_rdata == 8'hFF, "R11 reset rdata", io_rdata, 8'hFF);
        check(ld_en == '0, "R8 reset enables", 8'(ld_en), 8'h00);
        check(ld_sel == 8'h00, "R7 reset select", ld_sel, 8'h00);

        rd(DT, 8'hFF, "R4 shut data read");
        rd(IX, 8'hFF, "R11 shut index read");

        wr(IX, 8'h87); wr(IX, 8'h55); wr(IX, 8'h87);
        rd(DT, 8'hFF, "R3 interrupted key stays shut");
        wr(IX, 8'h87);
        rd(IX, 8'h00, "R2 open, index untouched");

        wr(IX, 8'h20); rd(DT, 8'h0A, "R6 dev hi");
        wr(IX, 8'h21); rd(DT, 8'h51, "R6 dev lo");
        wr(IX, 8'h22); rd(DT, 8'h03, "R6 rev");
        wr(IX, 8'h23); rd(DT, 8'h19, "R6 mfg hi");
        wr(IX, 8'h24); rd(DT, 8'h34, "R6 mfg lo");
        wr(IX, 8'h20); wr(DT, 8'h00); rd(DT, 8'h0A, "R6 id write ignored");

        wr(IX, 8'h26); wr(DT, 8'h3C); rd(DT, 8'h3C, "R10 global rw");
        wr(IX, 8'h10); wr(DT, 8'h77); rd(DT, 8'h00, "R10 unlisted reads zero");

        wr(IX, 8'h07); wr(DT, 8'h02); rd(DT, 8'h02, "R7 select rw");
        check(ld_sel == 8'h02, "R7 select port", ld_sel, 8'h02);
        wr(IX, 8'h30); wr(DT, 8'hFF);
        check(cap_wr == 1'b0, "R9 no strobe at 0x30", 8'(cap_wr), 8'h00);
        rd(DT, 8'h01, "R8 enable bit only");
        check(ld_en == 4'b0100, "R8 enable of device 2", 8'(ld_en), 8'h04);

        wr(IX, 8'h07); wr(DT, 8'h01);
        wr(IX, 8'h30); rd(DT, 8'h00, "R8 device 1 disabled");
        wr(IX, 8'h26); rd(DT, 8'h3C, "R10 shared under select 1");
        wr(DT, 8'h5A);
        wr(IX, 8'h07); wr(DT, 8'h02);
        wr(IX, 8'h26); rd(DT, 8'h5A, "R10 shared under select 2");
        wr(IX, 8'h30); rd(DT, 8'h01, "R8 device 2 still enabled");

        wr(IX, 8'h45); wr(DT, 8'h99);
        check(cap_wr == 1'b1, "R9 ld_wr strobe", 8'(cap_wr), 8'h01);
        check(cap_idx == 8'h45, "R9 ld_idx", cap_idx, 8'h45);
        check(cap_wdata == 8'h99, "R9 ld_wdata", cap_wdata, 8'h99);
        rd(DT, 8'hE0, "R9 downstream read data");
        check(cap_rd == 1'b1, "R9 ld_rd strobe", 8'(cap_rd), 8'h01);

        wr(IX, 8'h07); wr(DT, 8'h09);
        wr(IX, 8'h30); wr(DT, 8'h01);
        check(ld_en == 4'b0100, "R8 out-of-range select ignored", 8'(ld_en), 8'h04);
        rd(DT, 8'h00, "R8 out-of-range reads zero");

        wr(IX, 8'h45); wr(IX, 8'hAA);
        rd(DT, 8'hFF, "R5 closed by lock byte");
        wr(DT, 8'h11);
        check(cap_wr == 1'b0, "R4 no strobe when shut", 8'(cap_wr), 8'h00);
        wr(IX, 8'h26); wr(DT, 8'h00);
        wr(IX, 8'h87); wr(IX, 8'h87);
        rd(IX, 8'h45, "R4 index kept while shut");
        wr(IX, 8'h26); rd(DT, 8'h5A, "R4 global kept while shut");

        wr(IX, 8'hAA);
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
        rd(DT, 8'hFF, "R1 other base did not open");
        rd(16'h004F, 8'hFF, "R1 undecoded read");
        @(negedge clk) base_sel = 1;
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
        rd(16'h004E, 8'h26, "R1 strapped base index");
        rd(16'h004F, 8'h5A, "R1 strapped base data");
        rd(DT, 8'hFF, "R1 old base undecoded");

        wr(16'h004E, 8'hAA); wr(16'h004E, 8'h87); wr(16'h004F, 8'h00); wr(16'h004E, 8'h87);
        rd(16'h004F, 8'hFF, "R3 data write cancels key");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "SB_DRAIN", 8'(sb.size()), 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule